// File: doc/BRIEF.md
# Four-Bit Expression-Stack ALU

This block is the arithmetic unit of a zero-address processor. It keeps its own small expression stack and takes no operand addresses. Every operation reads the two top entries: TOS is the top and TOS1 is the one below it. The result always goes back to TOS. A two-operand operation consumes TOS1, so the stack shrinks by one. Shifts, rotates and inversion work on TOS alone and leave the depth as it is. A carry/borrow flag and a branch (zero) flag are kept beside the stack.

The surrounding core drives three kinds of request. It presents one of them while `ready` is high: an operation (`op_valid` with `op_code`), a push of `push_data`, or a pop. Each accepted request takes one machine cycle, which is two clocks. The accepting edge latches the request and starts a read of the spill memory that holds the entries below TOS1. The next edge commits the result. If a request needs more operands than the stack holds, the unit raises `underflow` for one cycle and changes nothing else.

Top module: `sac_stack_alu`

## Requirements
- R1: After reset, `depth` is 0, `carry`, `branch` and `underflow` are 0, and `ready` is 1.
- R2: A request is accepted on a rising edge where `ready` is 1. `ready` is then 0 for exactly one cycle, and the result is visible after the following edge. Requests seen while `ready` is 0 are ignored. When several requests arrive together, an operation wins over a push, and a push wins over a pop. Flags change only on a completion edge.
- R3: A push places `push_data` on top and raises `depth` by one. A push onto a full stack (`depth` = DEPTH) is ignored. A pop removes the top entry, so the former TOS1 becomes TOS and `depth` drops by one. A pop of an empty stack is ignored. Push and pop leave the flags unchanged.
- R4: Code 0 gives TOS1+TOS and code 1 gives TOS1+TOS+carry. In both, `carry` becomes the carry out of bit 3.
- R5: Code 2 gives TOS1−TOS and code 3 gives TOS1−TOS−carry, both modulo 16. In both, `carry` is set exactly when a borrow occurs.
- R6: Codes 4, 5 and 6 give TOS1 AND, OR and XOR TOS. Code 11 gives the bitwise inverse of TOS. None of them change `carry`.
- R7: Code 7 shifts TOS left and code 8 shifts it right. The vacated bit is filled with 0, and `carry` takes the bit shifted out.
- R8: Code 9 rotates TOS left through carry and code 10 rotates it right through carry. The old `carry` enters the vacated bit, and the bit shifted out becomes the new `carry`.
- R9: Codes 0 to 6 remove TOS1, so `depth` drops by one and the entry that was below TOS1 becomes the new TOS1. Codes 7 to 11 keep `depth`.
- R10: Every completed operation with codes 0 to 11 sets `branch` when its 4-bit result is zero and clears it otherwise.
- R11: Codes 0 to 6 need `depth` ≥ 2, and codes 7 to 11 need `depth` ≥ 1. If the stack is shallower, `underflow` is 1 for the single cycle after the completion edge, and the stack, `depth` and the flags stay unchanged.
- R12: Codes 12 to 15 are reserved. They complete like any request but change no stack entry, no flag and `depth`, and they never raise `underflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 4 | Operation code (see R4 to R12) |
| push_valid | input | 1 | Push request |
| push_data | input | W (4) | Value to push |
| pop_valid | input | 1 | Pop request |
| ready | output | 1 | Unit can accept a request on the next edge |
| tos | output | W (4) | Current top of stack (meaningful when depth > 0) |
| depth | output | $clog2(DEPTH+1) (5) | Number of entries held |
| carry | output | 1 | Carry/borrow flag |
| branch | output | 1 | Branch flag, set on a zero result |
| underflow | output | 1 | One-cycle pulse: the operation lacked operands |

## Verification
The bench goes after the borrow and carry-in paths of the chained add and subtract. A unit that inverted the borrow sense, or dropped the carry-in, would show a wrong `carry` or a result off by one. It runs rotates with both flag values, so a rotate that filled with 0 would be exposed. It also pops after a two-operand operation on a deep stack, which shows whether the spill entry really moved up into TOS1. Further cases cover the stack edges: empty pops, a push onto a full stack, and operations on stacks that are too shallow. An off-by-one depth check would corrupt `depth` or miss the underflow pulse. Requests held during the busy cycle and requests that arrive together test acceptance and priority. A wrong guard would let a second command slip in, or let the wrong one win.

// File: rtl/sac_pkg.sv
package sac_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10,
    OP_NOT = 4'd11
  } sac_op_e;

  typedef enum logic [1:0] {
    CMD_OP   = 2'd0,
    CMD_PUSH = 2'd1,
    CMD_POP  = 2'd2
  } sac_cmd_e;

  // operands an opcode consumes; 0 marks a reserved code
  function automatic logic [1:0] op_arity(sac_op_e op);
    if (op <= OP_XOR)      return 2'd2;
    else if (op <= OP_NOT) return 2'd1;
    else                   return 2'd0;
  endfunction

endpackage

// File: rtl/sac_alu_core.sv
module sac_alu_core
  import sac_pkg::*;
#(
  parameter int W = 4
) (
  input  sac_op_e      op,
  input  logic [W-1:0] a,     // TOS1
  input  logic [W-1:0] b,     // TOS
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);

  logic [W:0] ext;

  always_comb begin
    ext  = '0;
    res  = b;
    cout = cin;
    case (op)
      OP_ADD: begin ext = {1'b0, a} + {1'b0, b};                   res = ext[W-1:0]; cout = ext[W]; end
      OP_ADC: begin ext = {1'b0, a} + {1'b0, b} + (W+1)'(cin);     res = ext[W-1:0]; cout = ext[W]; end
      OP_SUB: begin ext = {1'b0, a} - {1'b0, b};                   res = ext[W-1:0]; cout = ext[W]; end
      OP_SBB: begin ext = {1'b0, a} - {1'b0, b} - (W+1)'(cin);     res = ext[W-1:0]; cout = ext[W]; end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_SHL: begin res = {b[W-2:0], 1'b0}; cout = b[W-1]; end
      OP_SHR: begin res = {1'b0, b[W-1:1]}; cout = b[0];   end
      OP_ROL: begin res = {b[W-2:0], cin};  cout = b[W-1]; end
      OP_ROR: begin res = {cin, b[W-1:1]};  cout = b[0];   end
      OP_NOT: res = ~b;
      default: begin res = b; cout = cin; end
    endcase
  end

endmodule

// File: rtl/sac_spill_ram.sv
module sac_spill_ram #(
  parameter int W  = 4,
  parameter int N  = 14,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [N];

  // one write port, one registered read port: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sac_stack_alu.sv
module sac_stack_alu
  import sac_pkg::*;
#(
  parameter  int W     = 4,
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic          push_valid,
  input  logic [W-1:0]  push_data,
  input  logic          pop_valid,
  output logic          ready,
  output logic [W-1:0]  tos,
  output logic [CW-1:0] depth,
  output logic          carry,
  output logic          branch,
  output logic          underflow
);

  localparam int NSPILL = DEPTH - 2;
  localparam int AW     = (NSPILL > 1) ? $clog2(NSPILL) : 1;

  logic          busy_q;
  sac_cmd_e      kind_q;
  sac_op_e       op_q;
  logic [W-1:0]  data_q;
  logic [W-1:0]  tos_q, nos_q;
  logic [CW-1:0] cnt_q;
  logic          c_q, z_q, uf_q;

  logic [W-1:0]  spill_rd;
  logic [AW-1:0] spill_raddr, spill_waddr;
  logic          spill_we;
  logic [W-1:0]  alu_res;
  logic          alu_c;
  logic [1:0]    need;

  assign need = op_arity(op_q);

  // read of the third entry starts on the accepting edge
  assign spill_raddr = (cnt_q >= CW'(3)) ? AW'(cnt_q - CW'(3)) : '0;
  assign spill_waddr = AW'(cnt_q - CW'(2));
  assign spill_we    = busy_q && (kind_q == CMD_PUSH) &&
                       (cnt_q < CW'(DEPTH)) && (cnt_q >= CW'(2));

  sac_spill_ram #(.W(W), .N(NSPILL), .AW(AW)) spill_i (
    .clk   (clk),
    .we    (spill_we),
    .waddr (spill_waddr),
    .wdata (nos_q),
    .raddr (spill_raddr),
    .rdata (spill_rd)
  );

  sac_alu_core #(.W(W)) alu_i (
    .op   (op_q),
    .a    (nos_q),
    .b    (tos_q),
    .cin  (c_q),
    .res  (alu_res),
    .cout (alu_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      kind_q <= CMD_OP;
      op_q   <= OP_ADD;
      data_q <= '0;
      tos_q  <= '0;
      nos_q  <= '0;
      cnt_q  <= '0;
      c_q    <= 1'b0;
      z_q    <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      uf_q <= 1'b0;
      if (!busy_q) begin
        if (op_valid || push_valid || pop_valid) begin
          busy_q <= 1'b1;
          data_q <= push_data;
          op_q   <= sac_op_e'(op_code);
          if (op_valid)        kind_q <= CMD_OP;
          else if (push_valid) kind_q <= CMD_PUSH;
          else                 kind_q <= CMD_POP;
        end
      end else begin
        busy_q <= 1'b0;
        case (kind_q)
          CMD_PUSH: begin
            if (cnt_q < CW'(DEPTH)) begin
              tos_q <= data_q;
              nos_q <= tos_q;
              cnt_q <= cnt_q + CW'(1);
            end
          end
          CMD_POP: begin
            if (cnt_q != '0) begin
              tos_q <= nos_q;
              nos_q <= spill_rd;
              cnt_q <= cnt_q - CW'(1);
            end
          end
          default: begin
            if (need != 2'd0) begin
              if (cnt_q < CW'(need)) begin
                uf_q <= 1'b1;
              end else begin
                tos_q <= alu_res;
                c_q   <= alu_c;
                z_q   <= (alu_res == '0);
                if (need == 2'd2) begin
                  nos_q <= spill_rd;
                  cnt_q <= cnt_q - CW'(1);
                end
              end
            end
          end
        endcase
      end
    end
  end

  assign ready     = !busy_q;
  assign tos       = tos_q;
  assign depth     = cnt_q;
  assign carry     = c_q;
  assign branch    = z_q;
  assign underflow = uf_q;

endmodule

// File: rtl/sac_stack_alu_chk.sv
module sac_stack_alu_chk #(
  parameter  int W     = 4,
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic [W-1:0]  tos,
  input logic [CW-1:0] depth,
  input logic          carry,
  input logic          branch,
  input logic          underflow
);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (depth == '0 && ready && !carry && !branch && !underflow));

  assert_busy_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    !ready |=> ready);

  assert_flags_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> ($stable(carry) && $stable(branch)));

  assert_depth_bound_R3: assert property (@(posedge clk) disable iff (rst)
    depth <= CW'(DEPTH));

  assert_depth_step_R3: assert property (@(posedge clk) disable iff (rst)
    (depth == $past(depth)) || (depth == $past(depth) + CW'(1)) ||
    (depth + CW'(1) == $past(depth)));

  assert_uf_keeps_state_R11: assert property (@(posedge clk) disable iff (rst)
    underflow |-> ($stable(depth) && $stable(tos) && $stable(carry) && $stable(branch)));

  assert_uf_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    underflow |=> !underflow);

  assert_uf_after_busy_R11: assert property (@(posedge clk) disable iff (rst)
    underflow |-> !$past(ready));

endmodule

bind sac_stack_alu sac_stack_alu_chk #(.W(W), .DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ready     (ready),
  .tos       (tos),
  .depth     (depth),
  .carry     (carry),
  .branch    (branch),
  .underflow (underflow)
);

// File: tb/sac_stack_alu_tb.sv
`timescale 1ns/1ps
module sac_stack_alu_tb_top;

  localparam int W     = 4;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [3:0]    op_code = '0;
  logic          push_valid = 1'b0;
  logic [W-1:0]  push_data = '0;
  logic          pop_valid = 1'b0;
  logic          ready;
  logic [W-1:0]  tos;
  logic [CW-1:0] depth;
  logic          carry, branch, underflow;

  sac_stack_alu #(.W(W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .push_valid(push_valid), .push_data(push_data), .pop_valid(pop_valid),
    .ready(ready), .tos(tos), .depth(depth), .carry(carry),
    .branch(branch), .underflow(underflow)
  );

  always #5 clk = ~clk;

  // behavioural reference: front of the queue is the top of stack
  int    stk[$];
  int    m_c = 0, m_z = 0, e_uf = 0, e_rdy = 1;
  int    n_cmp = 0, n_bad = 0;
  bit    live = 0;
  bit    done = 0;
  string cur_req = "R1";

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("depth", int'(depth), stk.size());
      chk("ready", int'(ready), e_rdy);
      chk("underflow", int'(underflow), e_uf);
      chk("carry", int'(carry), m_c);
      chk("branch", int'(branch), m_z);
      if (stk.size() > 0) chk("tos", int'(tos), stk[0]);
    end
  end

  function automatic void model_op(int op);
    int ar, a, b, r, s, c;
    ar = (op <= 6) ? 2 : (op <= 11) ? 1 : 0;
    if (ar == 0) return;                       // R12 reserved
    if (stk.size() < ar) begin e_uf = 1; return; end  // R11
    b = stk[0];
    a = (ar == 2) ? stk[1] : 0;
    c = m_c;
    case (op)
      0:  begin s = a + b;       r = s % 16; c = (s > 15) ? 1 : 0; end
      1:  begin s = a + b + m_c; r = s % 16; c = (s > 15) ? 1 : 0; end
      2:  begin s = a - b;       r = (s + 32) % 16; c = (s < 0) ? 1 : 0; end
      3:  begin s = a - b - m_c; r = (s + 32) % 16; c = (s < 0) ? 1 : 0; end
      4:  r = a & b;
      5:  r = a | b;
      6:  r = a ^ b;
      7:  begin r = (b * 2) % 16;        c = b / 8; end
      8:  begin r = b / 2;               c = b % 2; end
      9:  begin r = (b * 2) % 16 + m_c;  c = b / 8; end
      10: begin r = b / 2 + 8 * m_c;     c = b % 2; end
      default: r = 15 - b;
    endcase
    if (ar == 2) begin
      void'(stk.pop_front());
      void'(stk.pop_front());
      stk.push_front(r);
    end else begin
      stk[0] = r;
    end
    m_c = c;
    m_z = (r == 0) ? 1 : 0;
  endfunction

  // one request; optionally a push held during the busy cycle (R2)
  task automatic issue(bit vo, bit vpu, bit vpo, int op, int data, bit busy_push);
    @(negedge clk);
    op_valid = vo; push_valid = vpu; pop_valid = vpo;
    op_code = 4'(op); push_data = W'(data);
    @(posedge clk); #1;
    e_uf = 0; e_rdy = 0;
    @(negedge clk);
    op_valid = 0; pop_valid = 0;
    push_valid = busy_push;
    push_data = W'(7);
    @(posedge clk); #1;
    e_rdy = 1;
    if (vo) model_op(op);
    else if (vpu) begin if (stk.size() < DEPTH) stk.push_front(data); end
    else if (vpo) begin if (stk.size() > 0) void'(stk.pop_front()); end
    @(negedge clk);
    push_valid = 0;
    @(posedge clk); #1;
    e_uf = 0;
  endtask

  task automatic push(int d);   issue(0, 1, 0, 0, d, 0); endtask
  task automatic pop();         issue(0, 0, 1, 0, 0, 0); endtask
  task automatic op(int o);     issue(1, 0, 0, o, 0, 0); endtask

  task automatic clear_stack();
    while (stk.size() > 0) pop();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    live = 1;
    @(posedge clk); #1;

    cur_req = "R3";  pop();                  // empty pop ignored
    cur_req = "R11"; op(0); op(7);           // no operands
    cur_req = "R11"; push(5); op(2);         // one operand, binary
    cur_req = "R7";  op(7); op(8); op(8); op(8);
    cur_req = "R4";  push(9); push(8); op(0);
    push(7); push(9); op(1);
    push(15); push(1); op(0); push(0); push(0); op(1);
    cur_req = "R5";  push(3); push(5); op(2); push(6); push(2); op(3);
    push(4); push(4); op(3); push(8); push(2); op(2);
    cur_req = "R6";  push(12); push(10); op(4); push(12); push(3); op(5);
    push(9); op(6); op(11); op(11);
    cur_req = "R8";  push(9); op(9); op(9); op(10); op(10); op(10);
    push(0); op(9); op(10);
    cur_req = "R10"; push(6); push(6); op(2); push(5); push(5); op(6);
    push(8); op(7);
    cur_req = "R9";  clear_stack();
    for (int i = 1; i <= 6; i++) push(i);
    op(0); pop(); pop(); op(5); pop(); pop();
    cur_req = "R3";  clear_stack();
    for (int i = 0; i < DEPTH + 2; i++) push(i % 16);
    op(2); push(3);
    while (stk.size() > 0) pop();
    pop();
    cur_req = "R12"; push(4); push(2); for (int k = 12; k < 16; k++) op(k);
    cur_req = "R2";  issue(1, 1, 1, 0, 9, 0);   // op wins
    issue(0, 1, 1, 0, 11, 0);                    // push wins over pop
    issue(1, 0, 0, 7, 0, 1);                     // push during busy ignored
    issue(0, 0, 1, 0, 0, 1);
    cur_req = "R9";  clear_stack();
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4)      push($urandom_range(0, 15));
      else if (r < 5) pop();
      else            op($urandom_range(0, 15));
    end
    repeat (2) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule